// File: doc/BRIEF.md
# Event-to-Interrupt Aggregator

The block takes a stream of system events, one event index per clock, and folds them onto a small set of virtual interrupt lines. Each line feeds one input of a host interrupt controller. Every event index has its own programmable map entry. The entry names a target virtual interrupt and a status bit position inside that interrupt's 64-bit status word. A valid event sets the status bit its entry points to. Many unrelated events can therefore share one output line, and each of them keeps its own pending bit.

Each virtual interrupt also has a 64-bit enable mask. Its output line is held high as a level for as long as any pending bit in its status word is also enabled. A configuring agent uses a plain register write/read port to program the map entries and the enable masks, to clear status bits with a write-one-to-clear, and to read back all of this state. An event whose map entry is not marked valid is discarded. Each discarded event is counted in a small saturating error counter, which can also be read through the port.

Top module: `evt_irq_aggr`

## Requirements
- R1: After reset, irq_o is all zero. Every map entry, status word and enable mask reads back as zero, and the error counter reads zero.
- R2: cfg_addr_i[5:4] selects the region: 0 is a map entry, 1 is an enable mask, 2 is a status word, 3 is the error counter. cfg_addr_i[3:0] gives the event or virtual interrupt index. A map entry word holds the bit position in bits [5:0], the virtual interrupt in bits [7:6] and a valid flag in bit 8. Written values read back unchanged.
- R3: A valid event (evt_valid_i high with a valid map entry) sets its mapped status bit at the clock edge on which it is accepted. The matching irq_o line does not change before that edge and reflects the new bit right after it.
- R4: irq_o[v] is high exactly while the status word of v ANDed with the enable mask of v is non-zero. A pending but masked bit keeps the line low, and enabling that bit later raises the line.
- R5: A write to a status word clears each bit written as one and leaves every bit written as zero unchanged.
- R6: When an event and a clear hit the same status bit in the same cycle, the bit stays set.
- R7: An event whose map entry has the valid flag at zero changes no status bit. It increments the error counter, and the counter stops at its maximum value of 15.
- R8: When a map entry is written in the same cycle as an event for that index, the event uses the old mapping. The next event for that index uses the new mapping.
- R9: Several events mapped to different bits of one virtual interrupt each hold their own bit. The line stays high until all of those enabled bits are cleared.
- R10: Map entries change only through port writes and status bits fall only through clears. Events never alter a map entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| evt_valid_i | input | 1 | Event strobe, one event per cycle |
| evt_idx_i | input | 4 | Index of the incoming event |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 6 | Register address: region in [5:4], index in [3:0] |
| cfg_wdata_i | input | 64 | Register write data |
| cfg_rdata_o | output | 64 | Register read data, combinational from cfg_addr_i |
| irq_o | output | 4 | Level interrupt line per virtual interrupt |

## Verification
A vector table sends a sequence of events that mixes fresh virtual interrupts, second bits on an interrupt that is already pending, an unmapped index and a fully masked interrupt. From this sequence the bench can tell a line that rises on a new pending bit apart from a line that merely stays high, and tell both apart from a line that a drop or a mask keeps low. Directed cases then line up an event with a clear of the same bit, and an event with a rewrite of its own map entry. These cases tell set-over-clear and old-map-in-flight ordering apart from their opposites. A burst of unmapped events drives the error counter into saturation while the bench confirms that no status word moved.

// File: rtl/evt_irq_aggr_pkg.sv
package evt_irq_aggr_pkg;
  localparam int unsigned BITS_PER_VINT = 64;
  localparam int unsigned BIT_W         = $clog2(BITS_PER_VINT);
  localparam int unsigned DATA_W        = 64;

  typedef enum logic [1:0] {
    REG_MAP  = 2'd0,
    REG_EN   = 2'd1,
    REG_STAT = 2'd2,
    REG_ERR  = 2'd3
  } reg_region_e;
endpackage

// File: rtl/evt_map_table.sv
module evt_map_table #(
  parameter int unsigned NUM_EVT = 16,
  parameter int unsigned ENT_W   = 9,
  localparam int unsigned EVT_W  = (NUM_EVT > 1) ? $clog2(NUM_EVT) : 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_en_i,
  input  logic [EVT_W-1:0]         wr_idx_i,
  input  logic [ENT_W-1:0]         wr_data_i,
  output logic [NUM_EVT*ENT_W-1:0] map_flat_o
);
  for (genvar e = 0; e < NUM_EVT; e++) begin : g_ent
    logic [ENT_W-1:0] ent_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ent_q <= '0;
      end else if (wr_en_i && wr_idx_i == EVT_W'(e)) begin
        ent_q <= wr_data_i;
      end
    end
    assign map_flat_o[e*ENT_W +: ENT_W] = ent_q;
  end
endmodule

// File: rtl/vint_bank.sv
module vint_bank #(
  parameter int unsigned NBITS = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NBITS-1:0] set_i,
  input  logic [NBITS-1:0] clr_i,
  input  logic             en_we_i,
  input  logic [NBITS-1:0] en_data_i,
  output logic [NBITS-1:0] status_o,
  output logic [NBITS-1:0] enable_o,
  output logic             irq_o
);
  logic [NBITS-1:0] status_q, enable_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= '0;
      enable_q <= '0;
    end else begin
      // set applied after clear: a same-cycle event wins
      status_q <= (status_q & ~clr_i) | set_i;
      if (en_we_i) enable_q <= en_data_i;
    end
  end

  assign status_o = status_q;
  assign enable_o = enable_q;
  assign irq_o    = |(status_q & enable_q);
endmodule

// File: rtl/err_counter.sv
module err_counter #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  output logic [CNT_W-1:0] count_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (inc_i && cnt_q != '1) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign count_o = cnt_q;
endmodule

// File: rtl/evt_irq_aggr.sv
module evt_irq_aggr
  import evt_irq_aggr_pkg::*;
#(
  parameter int unsigned NUM_EVT  = 16,
  parameter int unsigned NUM_VINT = 4,
  parameter int unsigned ERR_W    = 4,
  localparam int unsigned EVT_W   = (NUM_EVT > 1) ? $clog2(NUM_EVT) : 1,
  localparam int unsigned VINT_W  = (NUM_VINT > 1) ? $clog2(NUM_VINT) : 1,
  localparam int unsigned IDX_W   = (EVT_W > VINT_W) ? EVT_W : VINT_W,
  localparam int unsigned ADDR_W  = IDX_W + 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                evt_valid_i,
  input  logic [EVT_W-1:0]    evt_idx_i,
  input  logic                cfg_we_i,
  input  logic [ADDR_W-1:0]   cfg_addr_i,
  input  logic [DATA_W-1:0]   cfg_wdata_i,
  output logic [DATA_W-1:0]   cfg_rdata_o,
  output logic [NUM_VINT-1:0] irq_o
);
  localparam int unsigned ENT_W = 1 + VINT_W + BIT_W;
  localparam logic [IDX_W:0]  EVT_LIM  = (IDX_W+1)'(NUM_EVT);
  localparam logic [IDX_W:0]  VINT_LIM = (IDX_W+1)'(NUM_VINT);
  localparam logic [VINT_W:0] VSEL_LIM = (VINT_W+1)'(NUM_VINT);

  reg_region_e      region;
  logic [IDX_W-1:0] idx;
  logic             idx_evt_ok, idx_vint_ok;

  assign region      = reg_region_e'(cfg_addr_i[ADDR_W-1 -: 2]);
  assign idx         = cfg_addr_i[IDX_W-1:0];
  assign idx_evt_ok  = {1'b0, idx} < EVT_LIM;
  assign idx_vint_ok = {1'b0, idx} < VINT_LIM;

  // map table
  logic [NUM_EVT*ENT_W-1:0] map_flat;
  logic                     map_we;

  assign map_we = cfg_we_i && region == REG_MAP && idx_evt_ok;

  evt_map_table #(
    .NUM_EVT (NUM_EVT),
    .ENT_W   (ENT_W)
  ) i_map (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (map_we),
    .wr_idx_i   (idx[EVT_W-1:0]),
    .wr_data_i  (cfg_wdata_i[ENT_W-1:0]),
    .map_flat_o (map_flat)
  );

  // event lookup against the map as it stands before the edge
  logic [ENT_W-1:0]  lk_ent;
  logic              lk_valid;
  logic [VINT_W-1:0] lk_vint;
  logic [BIT_W-1:0]  lk_bit;
  logic              evt_hit, evt_drop;

  always_comb begin
    lk_ent = '0;
    for (int e = 0; e < NUM_EVT; e++) begin
      if (evt_idx_i == EVT_W'(e)) lk_ent = map_flat[e*ENT_W +: ENT_W];
    end
  end

  assign lk_bit   = lk_ent[BIT_W-1:0];
  assign lk_vint  = lk_ent[BIT_W +: VINT_W];
  assign lk_valid = lk_ent[ENT_W-1];
  assign evt_hit  = evt_valid_i && lk_valid && ({1'b0, lk_vint} < VSEL_LIM);
  assign evt_drop = evt_valid_i && !evt_hit;

  // virtual interrupt banks
  logic [BITS_PER_VINT-1:0]          status_w [NUM_VINT];
  logic [BITS_PER_VINT-1:0]          enable_w [NUM_VINT];
  logic [NUM_VINT*BITS_PER_VINT-1:0] status_flat, enable_flat;

  for (genvar v = 0; v < NUM_VINT; v++) begin : g_vint
    logic                     sel, en_we;
    logic [BITS_PER_VINT-1:0] set_v, clr_v;

    assign sel   = idx == IDX_W'(v);
    assign en_we = cfg_we_i && region == REG_EN && sel;
    assign clr_v = (cfg_we_i && region == REG_STAT && sel) ? cfg_wdata_i : '0;
    assign set_v = (evt_hit && lk_vint == VINT_W'(v))
                   ? (BITS_PER_VINT'(1) << lk_bit) : '0;

    vint_bank #(
      .NBITS (BITS_PER_VINT)
    ) i_bank (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .set_i     (set_v),
      .clr_i     (clr_v),
      .en_we_i   (en_we),
      .en_data_i (cfg_wdata_i),
      .status_o  (status_w[v]),
      .enable_o  (enable_w[v]),
      .irq_o     (irq_o[v])
    );

    assign status_flat[v*BITS_PER_VINT +: BITS_PER_VINT] = status_w[v];
    assign enable_flat[v*BITS_PER_VINT +: BITS_PER_VINT] = enable_w[v];
  end

  // error counter
  logic [ERR_W-1:0] err_cnt;

  err_counter #(
    .CNT_W (ERR_W)
  ) i_err (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .inc_i   (evt_drop),
    .count_o (err_cnt)
  );

  // read mux
  always_comb begin
    cfg_rdata_o = '0;
    unique case (region)
      REG_MAP: begin
        for (int e = 0; e < NUM_EVT; e++) begin
          if (idx == IDX_W'(e))
            cfg_rdata_o = {{(DATA_W-ENT_W){1'b0}}, map_flat[e*ENT_W +: ENT_W]};
        end
      end
      REG_EN: begin
        for (int v = 0; v < NUM_VINT; v++) begin
          if (idx == IDX_W'(v)) cfg_rdata_o = enable_w[v];
        end
      end
      REG_STAT: begin
        for (int v = 0; v < NUM_VINT; v++) begin
          if (idx == IDX_W'(v)) cfg_rdata_o = status_w[v];
        end
      end
      REG_ERR: cfg_rdata_o = {{(DATA_W-ERR_W){1'b0}}, err_cnt};
      default: cfg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/evt_irq_aggr_chk.sv
module evt_irq_aggr_chk #(
  parameter int unsigned NUM_EVT  = 16,
  parameter int unsigned NUM_VINT = 4,
  parameter int unsigned ENT_W    = 9,
  parameter int unsigned VINT_W   = 2,
  parameter int unsigned BIT_W    = 6,
  parameter int unsigned ERR_W    = 4,
  localparam int unsigned SW      = NUM_VINT * (1 << BIT_W)
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     cfg_we_i,
  input logic                     evt_hit,
  input logic [VINT_W-1:0]        lk_vint,
  input logic [BIT_W-1:0]         lk_bit,
  input logic [SW-1:0]            status_flat,
  input logic [SW-1:0]            enable_flat,
  input logic [NUM_VINT-1:0]      irq_o,
  input logic [ERR_W-1:0]         err_cnt,
  input logic [NUM_EVT*ENT_W-1:0] map_flat
);
  logic [VINT_W+BIT_W-1:0] lin;
  assign lin = {lk_vint, lk_bit};

  // R3
  a_r3_event_sets_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_hit |=> status_flat[$past(lin)]);

  // R4
  a_r4_irq_needs_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o != '0) |-> ((status_flat & enable_flat) != '0));

  // R7
  a_r7_err_no_decrement: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> err_cnt >= $past(err_cnt));

  // R10
  a_r10_map_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_we_i |=> $stable(map_flat));

  // R10
  a_r10_status_no_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_we_i |=> (($past(status_flat) & ~status_flat) == '0));
endmodule

bind evt_irq_aggr evt_irq_aggr_chk #(
  .NUM_EVT  (NUM_EVT),
  .NUM_VINT (NUM_VINT),
  .ENT_W    (ENT_W),
  .VINT_W   (VINT_W),
  .BIT_W    (evt_irq_aggr_pkg::BIT_W),
  .ERR_W    (ERR_W)
) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cfg_we_i    (cfg_we_i),
  .evt_hit     (evt_hit),
  .lk_vint     (lk_vint),
  .lk_bit      (lk_bit),
  .status_flat (status_flat),
  .enable_flat (enable_flat),
  .irq_o       (irq_o),
  .err_cnt     (err_cnt),
  .map_flat    (map_flat)
);

// File: tb/test_evt_irq_aggr.sv
module test_evt_irq_aggr;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        evt_valid_i = 1'b0;
  logic [3:0]  evt_idx_i = '0;
  logic        cfg_we_i = 1'b0;
  logic [5:0]  cfg_addr_i = '0;
  logic [63:0] cfg_wdata_i = '0;
  logic [63:0] cfg_rdata_o;
  logic [3:0]  irq_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #4 clk_i = ~clk_i;

  evt_irq_aggr i_evt_irq_aggr (
    .clk_i, .rst_ni, .evt_valid_i, .evt_idx_i, .cfg_we_i,
    .cfg_addr_i, .cfg_wdata_i, .cfg_rdata_o, .irq_o
  );

  // bench model
  bit          bm_valid [16];
  logic [1:0]  bm_vint  [16];
  logic [5:0]  bm_bit   [16];
  logic [63:0] exp_st   [4];
  logic [63:0] exp_en   [4];
  int          exp_err;

  localparam int NROW = 7;
  localparam logic [3:0] V_IDX [NROW] = '{4'd0, 4'd1, 4'd4, 4'd2, 4'd13, 4'd3, 4'd5};
  localparam logic [3:0] V_IRQ [NROW] = '{4'b0001, 4'b0011, 4'b0011, 4'b0111,
                                          4'b0111, 4'b0111, 4'b0111};

  function automatic logic [5:0] ad(input logic [1:0] r, input logic [3:0] i);
    return {r, i};
  endfunction

  function automatic logic [63:0] mw(input logic [1:0] v, input logic [5:0] b);
    return 64'h100 | (64'(v) << 6) | 64'(b);
  endfunction

  function automatic logic [3:0] exp_irq();
    logic [3:0] r;
    for (int v = 0; v < 4; v++) r[v] = |(exp_st[v] & exp_en[v]);
    return r;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [5:0] a, output logic [63:0] d);
    cfg_addr_i = a;
    #1;
    d = cfg_rdata_o;
  endtask

  task automatic wr(input logic [5:0] a, input logic [63:0] d);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_addr_i = a; cfg_wdata_i = d;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  task automatic model_evt(input int i);
    if (bm_valid[i]) exp_st[bm_vint[i]][bm_bit[i]] = 1'b1;
    else if (exp_err < 15) exp_err++;
  endtask

  task automatic send(input int i);
    @(negedge clk_i);
    evt_valid_i = 1'b1; evt_idx_i = 4'(i);
    @(negedge clk_i);
    evt_valid_i = 1'b0;
    model_evt(i);
  endtask

  task automatic map_set(input int e, input logic [1:0] v, input logic [5:0] b);
    wr(ad(2'd0, 4'(e)), mw(v, b));
    bm_valid[e] = 1'b1; bm_vint[e] = v; bm_bit[e] = b;
  endtask

  task automatic check_status(input string req);
    logic [63:0] d;
    for (int v = 0; v < 4; v++) begin
      rd(ad(2'd2, 4'(v)), d);
      check(req, d, exp_st[v]);
    end
  endtask

  initial begin
    logic [63:0] d;
    for (int e = 0; e < 16; e++) begin bm_valid[e] = 0; bm_vint[e] = 0; bm_bit[e] = 0; end
    for (int v = 0; v < 4; v++) begin exp_st[v] = '0; exp_en[v] = '0; end
    exp_err = 0;

    // R1 reset state
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 irq", 64'(irq_o), 64'h0);
    rd(ad(2'd0, 4'd0), d);  check("R1 map0", d, 64'h0);
    rd(ad(2'd0, 4'd15), d); check("R1 map15", d, 64'h0);
    rd(ad(2'd1, 4'd2), d);  check("R1 enable2", d, 64'h0);
    rd(ad(2'd3, 4'd0), d);  check("R1 err", d, 64'h0);
    check_status("R1 status");

    // program map: events 0..11 valid, 12..15 left invalid
    for (int e = 0; e < 12; e++) map_set(e, 2'(e % 4), 6'((e * 5) % 64));
    rd(ad(2'd0, 4'd5), d); check("R2 map5 readback", d, 64'h159);
    for (int v = 0; v < 3; v++) begin
      wr(ad(2'd1, 4'(v)), '1); exp_en[v] = '1;
    end
    rd(ad(2'd1, 4'd1), d); check("R2 enable1 readback", d, '1);
    rd(ad(2'd1, 4'd3), d); check("R2 enable3 readback", d, 64'h0);
    check("R4 enabled but idle", 64'(irq_o), 64'h0);

    // vector table walk
    for (int r = 0; r < NROW; r++) begin
      logic [3:0] prev;
      prev = exp_irq();
      @(negedge clk_i);
      evt_valid_i = 1'b1; evt_idx_i = V_IDX[r];
      #1;
      check("R3 no change before edge", 64'(irq_o), 64'(prev));
      @(negedge clk_i);
      evt_valid_i = 1'b0;
      model_evt(int'(V_IDX[r]));
      check("R3 R9 table irq", 64'(irq_o), 64'(V_IRQ[r]));
      check("R3 table irq model", 64'(V_IRQ[r]), 64'(exp_irq()));
      check_status("R3 R9 table status");
    end
    rd(ad(2'd3, 4'd0), d); check("R7 one drop counted", d, 64'd1);

    // R4 masked pending bit then enable
    rd(ad(2'd2, 4'd3), d); check("R4 masked pending status", d, 64'h1 << 15);
    check("R4 masked line low", 64'(irq_o[3]), 64'h0);
    wr(ad(2'd1, 4'd3), 64'h1 << 15); exp_en[3] = 64'h1 << 15;
    check("R4 enable raises line", 64'(irq_o), 64'hf);

    // R5 write-one-to-clear
    wr(ad(2'd2, 4'd0), 64'h0);
    rd(ad(2'd2, 4'd0), d); check("R5 zero write keeps", d, 64'h1 | (64'h1 << 20));
    wr(ad(2'd2, 4'd0), 64'h1); exp_st[0][0] = 1'b0;
    rd(ad(2'd2, 4'd0), d); check("R5 clear bit0", d, 64'h1 << 20);
    check("R9 line held by other bit", 64'(irq_o[0]), 64'h1);

    // R6 set wins over clear
    @(negedge clk_i);
    evt_valid_i = 1'b1; evt_idx_i = 4'd0;
    cfg_we_i = 1'b1; cfg_addr_i = ad(2'd2, 4'd0); cfg_wdata_i = 64'h1;
    @(negedge clk_i);
    evt_valid_i = 1'b0; cfg_we_i = 1'b0;
    model_evt(0);
    rd(ad(2'd2, 4'd0), d); check("R6 set wins", d, 64'h1 | (64'h1 << 20));

    // R9 clear all bits of vint0
    wr(ad(2'd2, 4'd0), 64'h1 | (64'h1 << 20)); exp_st[0] = '0;
    check("R9 line falls after all cleared", 64'(irq_o), 64'he);

    // R8 remap in same cycle as event
    @(negedge clk_i);
    evt_valid_i = 1'b1; evt_idx_i = 4'd6;
    cfg_we_i = 1'b1; cfg_addr_i = ad(2'd0, 4'd6); cfg_wdata_i = mw(2'd0, 6'd63);
    @(negedge clk_i);
    evt_valid_i = 1'b0; cfg_we_i = 1'b0;
    model_evt(6);
    bm_vint[6] = 2'd0; bm_bit[6] = 6'd63;
    rd(ad(2'd2, 4'd2), d); check("R8 old mapping used", d, exp_st[2]);
    rd(ad(2'd2, 4'd0), d); check("R8 new mapping not yet", d, 64'h0);
    send(6);
    rd(ad(2'd2, 4'd0), d); check("R8 new mapping applies", d, 64'h1 << 63);
    check("R8 irq", 64'(irq_o), 64'(exp_irq()));

    // R7 saturation, dropped events have no effect
    for (int k = 0; k < 20; k++) send(14);
    rd(ad(2'd3, 4'd0), d); check("R7 err saturates", d, 64'd15);
    check_status("R7 drops leave status");
    check("R7 drops leave irq", 64'(irq_o), 64'(exp_irq()));

    // R10 map untouched by events
    rd(ad(2'd0, 4'd0), d); check("R10 map0 unchanged", d, mw(2'd0, 6'd0));
    rd(ad(2'd0, 4'd14), d); check("R10 map14 still invalid", d, 64'h0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule